// File: doc/BRIEF.md
# Serial Peripheral Interrupt Status and Routing

This block keeps the interrupt state of a serial port. Eleven event sources set bits in a raw status word. A mask-enable word selects which of those bits may raise an interrupt. Software reaches both words through a small register bus. It can read the raw and the masked status separately, and it acknowledges events by writing ones to a clear register.

The masked status is fanned out onto six registered interrupt lines. One line is the OR of every source. The other five each cover one source group: receive, transmit, receive timeout, modem status and errors. A bus write to the transmit data register also counts as a transmit event. The block does not generate the other events; it only records them from its event inputs.

Reads are combinational: `rdata_o` reflects the addressed register in the same cycle that `req_i` is high with `we_i` low. Writes take effect at the next rising clock edge.

Top module: `uart_irq_router`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the raw status, the mask-enable word and all six interrupt lines are zero.
- R2: A write to address 1 loads bits 10:0 of `wdata_i` into the mask-enable word. A read of address 1 returns that word, with bits 15:11 reading zero.
- R3: A read of address 2 returns the raw status. A read of address 3 returns the raw status ANDed with the mask-enable word.
- R4: A write to address 4 clears every raw status bit whose bit in `wdata_i` is 1 and leaves the other raw bits unchanged. A read of address 4 returns 0.
- R5: Writes to address 2 and to address 3 leave the raw status and the mask-enable word unchanged.
- R6: A high bit k of `evt_i` at a rising edge sets raw bit k. If a clear write names bit k in the same cycle, the bit still ends up set.
- R7: Any write to address 0 (transmit data) sets raw bit 5, whatever value is written. Address 0 reads as 0.
- R8: The raw bit layout is: bit 0 ring indicator, bit 1 clear-to-send, bit 2 carrier detect, bit 3 data-set-ready, bit 4 receive, bit 5 transmit, bit 6 receive timeout, and bits 7 to 10 the four error bits (framing, parity, break, overrun). The lines are:
  - `irq_o[0]`: high when any masked bit is set.
  - `irq_o[1]`: masked bit 4.
  - `irq_o[2]`: masked bit 5.
  - `irq_o[3]`: masked bit 6.
  - `irq_o[4]`: any of masked bits 3:0.
  - `irq_o[5]`: any of masked bits 10:7.
- R9: The interrupt lines are registered. They change at the same rising edge at which the status or the mask-enable word changes.
- R10: Reads of addresses 5 to 7 return 0, and writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| evt_i | input | 11 | Event set pulses, one per raw bit |
| irq_o | output | 6 | Interrupt lines: combined, rx, tx, timeout, modem, error |

## Verification
Two things can land on the same raw bit in one cycle: an event pulse that sets it and a clear write that names it. The bench drives both in the same cycle for every bit position. It expects the bit to read back set, and the matching interrupt line to stay high, after that edge. The bench also pairs a clear write with pulses on other bits, and expects the cleared bits to drop while the pulsed bits rise. Separately, it sweeps all 2048 mask values against a fully set raw word and compares each line with group ORs computed in the bench.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC   = 11;
  localparam int NLINE  = 6;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int BIT_TX = 5;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum logic [ADDR_W-1:0] {
    ADR_TXDATA = 3'd0,
    ADR_MASK   = 3'd1,
    ADR_RAW    = 3'd2,
    ADR_MASKED = 3'd3,
    ADR_CLEAR  = 3'd4
  } reg_adr_e;

  // group mask per output line, index order is the line order
  function automatic src_vec_t line_mask(input int k);
    case (k)
      0:       line_mask = '1;
      1:       line_mask = src_vec_t'(11'h010);
      2:       line_mask = src_vec_t'(11'h020);
      3:       line_mask = src_vec_t'(11'h040);
      4:       line_mask = src_vec_t'(11'h00F);
      default: line_mask = src_vec_t'(11'h780);
    endcase
  endfunction
endpackage

// File: rtl/uirq_bus_decode.sv
module uirq_bus_decode
  import uirq_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  src_vec_t          raw_q_i,
  input  src_vec_t          mask_q_i,
  output logic              tx_wr_o,
  output logic              mask_we_o,
  output logic              clr_we_o,
  output src_vec_t          wr_vec_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr;
  assign wr        = req_i & we_i;
  assign tx_wr_o   = wr & (addr_i == ADR_TXDATA);
  assign mask_we_o = wr & (addr_i == ADR_MASK);
  assign clr_we_o  = wr & (addr_i == ADR_CLEAR);
  assign wr_vec_o  = wdata_i[NSRC-1:0];

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        ADR_MASK:   rdata_o = DATA_W'(mask_q_i);
        ADR_RAW:    rdata_o = DATA_W'(raw_q_i);
        ADR_MASKED: rdata_o = DATA_W'(raw_q_i & mask_q_i);
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/uirq_status_regs.sv
module uirq_status_regs
  import uirq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  logic     tx_wr_i,
  input  logic     mask_we_i,
  input  logic     clr_we_i,
  input  src_vec_t wr_vec_i,
  output src_vec_t raw_q_o,
  output src_vec_t mask_q_o,
  output src_vec_t masked_d_o
);
  src_vec_t raw_q, mask_q, raw_d, mask_d, set_vec, clr_vec;

  always_comb begin
    set_vec = evt_i;
    if (tx_wr_i) set_vec[BIT_TX] = 1'b1;
    clr_vec = clr_we_i ? wr_vec_i : '0;
    // set wins over clear on the same bit
    raw_d  = (raw_q & ~clr_vec) | set_vec;
    mask_d = mask_we_i ? wr_vec_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_q_o    = raw_q;
  assign mask_q_o   = mask_q;
  assign masked_d_o = raw_d & mask_d;

  a_r4_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((raw_q & $past(wr_vec_i & ~evt_i & ~(tx_wr_i ? src_vec_t'(1 << BIT_TX) : '0))) == '0));
  a_r6_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));
  a_r7_tx_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> raw_q[BIT_TX]);
  a_r5_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/uirq_line_fanout.sv
module uirq_line_fanout
  import uirq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_vec_t         masked_d_i,
  output logic [NLINE-1:0] irq_o
);
  logic [NLINE-1:0] irq_q;

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[k] <= 1'b0;
      else         irq_q[k] <= |(masked_d_i & line_mask(k));
    end
  end

  assign irq_o = irq_q;

  a_r8_combined_is_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q[0] == (|irq_q[NLINE-1:1]));
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
  import uirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NSRC-1:0]   evt_i,
  output logic [NLINE-1:0]  irq_o
);
  logic     tx_wr, mask_we, clr_we;
  src_vec_t wr_vec, raw_q, mask_q, masked_d;

  uirq_bus_decode i_decode (
    .req_i, .we_i, .addr_i, .wdata_i,
    .raw_q_i(raw_q), .mask_q_i(mask_q),
    .tx_wr_o(tx_wr), .mask_we_o(mask_we), .clr_we_o(clr_we),
    .wr_vec_o(wr_vec), .rdata_o
  );

  uirq_status_regs i_status (
    .clk_i, .rst_ni, .evt_i,
    .tx_wr_i(tx_wr), .mask_we_i(mask_we), .clr_we_i(clr_we), .wr_vec_i(wr_vec),
    .raw_q_o(raw_q), .mask_q_o(mask_q), .masked_d_o(masked_d)
  );

  uirq_line_fanout i_fanout (
    .clk_i, .rst_ni, .masked_d_i(masked_d), .irq_o
  );

  a_r9_lines_track_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_q & mask_q) == '0) |-> (irq_o == '0));
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0 && raw_q == '0 && mask_q == '0));
endmodule

// File: tb/test_uart_irq_router.sv
`timescale 1ns/1ps
module test_uart_irq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [10:0] evt_i = '0;
  logic [5:0]  irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  uart_irq_router i_uart_irq_router (.*);

  function automatic logic [5:0] exp_lines(input logic [10:0] m);
    logic [5:0] l;
    l[1] = m[4];
    l[2] = m[5];
    l[3] = m[6];
    l[4] = |m[3:0];
    l[5] = |m[10:7];
    l[0] = |m;
    return l;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [10:0] e = '0);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; evt_i = e;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [10:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #0.5 d = rdata_o;
    req_i = 1'b0;
  endtask

  initial begin : watchdog
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    logic [10:0] rawm, maskm;

    #1;
    chk("R1 lines in reset", 16'(irq_o), 16'h0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(3'd2, d); chk("R1 raw after reset", d, 16'h0);
    rd(3'd1, d); chk("R1 mask after reset", d, 16'h0);
    chk("R1 lines after reset", 16'(irq_o), 16'h0);

    // R2 mask readback, upper bits zero
    wr(3'd1, 16'hFFFF);
    rd(3'd1, d); chk("R2 mask readback", d, 16'h07FF);
    wr(3'd1, 16'h0000);
    rd(3'd1, d); chk("R2 mask cleared", d, 16'h0);

    // R7 tx write sets bit 5, data irrelevant; address 0 reads 0
    wr(3'd0, 16'h00A5);
    rd(3'd2, d); chk("R7 tx raw bit", d, 16'h0020);
    rd(3'd0, d); chk("R7 txdata reads 0", d, 16'h0);
    chk("R9 masked-off line stays low", 16'(irq_o), 16'h0);
    wr(3'd1, 16'h0020);
    chk("R9 line rises with mask write", 16'(irq_o), 16'h0005);
    wr(3'd4, 16'h0020);
    chk("R9 line falls with clear", 16'(irq_o), 16'h0);
    rd(3'd2, d); chk("R4 tx cleared", d, 16'h0);

    // per-bit sweep: event set, lines, clear, same-cycle set/clear
    for (int b = 0; b < 11; b++) begin
      maskm = 11'(1) << b;
      wr(3'd1, 16'(maskm));
      pulse(maskm);
      rd(3'd2, d); chk("R6 event sets bit", d, 16'(maskm));
      rd(3'd3, d); chk("R3 masked read", d, 16'(maskm));
      chk("R8 line map single bit", 16'(irq_o), 16'(exp_lines(maskm)));
      wr(3'd4, 16'(maskm), maskm);
      rd(3'd2, d); chk("R6 set wins over clear", d, 16'(maskm));
      chk("R6 line held on set/clear", 16'(irq_o), 16'(exp_lines(maskm)));
      wr(3'd4, 16'(maskm));
      rd(3'd2, d); chk("R4 clear drops bit", d, 16'h0);
      chk("R9 lines drop on clear", 16'(irq_o), 16'h0);
    end

    // clear some bits while events set others
    wr(3'd1, 16'h07FF);
    pulse(11'h0F3);
    wr(3'd4, 16'h0033, 11'h500);
    rd(3'd2, d); chk("R4 partial clear with events", d, 16'h05C0);
    chk("R8 lines after partial clear", 16'(irq_o), 16'(exp_lines(11'h5C0)));

    // R5 / R10 ignored writes
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0000);
    wr(3'd5, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    rd(3'd2, d); chk("R5 raw unchanged", d, 16'h05C0);
    rd(3'd1, d); chk("R5 mask unchanged", d, 16'h07FF);
    rd(3'd4, d); chk("R4 clear reads 0", d, 16'h0);
    rd(3'd5, d); chk("R10 addr5 reads 0", d, 16'h0);
    rd(3'd6, d); chk("R10 addr6 reads 0", d, 16'h0);

    // exhaustive mask sweep with all raw bits set
    pulse(11'h7FF);
    rawm = 11'h7FF;
    for (int m = 0; m < 2048; m++) begin
      wr(3'd1, 16'(m));
      chk("R8 sweep lines", 16'(irq_o), 16'(exp_lines(rawm & 11'(m))));
      if (m % 64 == 0) begin
        rd(3'd3, d); chk("R3 sweep masked", d, 16'(rawm & 11'(m)));
      end
    end

    // R1 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 chk("R1 async reset lines", 16'(irq_o), 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(3'd2, d); chk("R1 raw after second reset", d, 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule